// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block turns interrupt requests into a single prioritised request for a processor core. There are four fixed core sources (emulation, reset, power-down and a stack-overflow line). There are also fifteen peripheral sources. Software gives each peripheral a priority level, which places it on one of sixteen request positions. Requests are latched into a pending register, which software can also set or clear directly. The pending bits are gated by a mask register and a global enable, and the lowest-numbered surviving position is presented to the core as an index and a vector address.

The core accepts an offered request with `irq_ack`. This clears the pending bit and records the level as in service. It signals the end of the handler with `irq_done`. A control bit chooses between two modes. In sequential mode nothing new is offered while a handler runs. In nested mode only a strictly more urgent request may interrupt one in service. All priority, mask and control state sits behind a small synchronous register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, peripheral ID i holds priority min(i, 11). Read at addresses 4..7 the priority registers give 0x3210, 0x7654, 0xBA98 and 0x0BBB. Control, mask, pending and the power-down block all read zero, and `irq_valid` is low.
- R2: The priority of peripheral ID i sits at address 4 + i/4, bits [4*(i%4)+3 : 4*(i%4)]. A request from a peripheral at level p sets pending bit p+4 on the next clock edge.
- R3: A priority value above 11 written to a field is stored and read back as 11.
- R4: A pending bit at position 3..15 may be offered only when its mask bit (address 1) is set and control bit 5 (global enable) is set. Of the eligible positions, the lowest index is reported on `irq_idx`.
- R5: `irq_vector` equals `irq_idx` * 0x20, plus 0x10000 when `noboot` is high.
- R6: Positions 0 (emulation), 1 (reset) and 2 (power-down) ignore the mask and the global enable. Position 2 is withheld while bit 0 of address 8 is set.
- R7: In the control register (address 0) only bits 4, 5, 10 and 11 can be written. Every other bit reads zero.
- R8: Position 3 is set by `pc_ovf` when control bit 10 is set, and by `loop_ovf` when control bit 11 is set. Otherwise these inputs have no effect.
- R9: A write to address 2 sets every pending bit written as one. A write to address 3 clears every pending bit written as one. Both addresses read back the pending register. A hardware request in the same cycle as a clear leaves its bit set.
- R10: `irq_ack` while `irq_valid` is high clears pending bit `irq_idx` and marks that level in service. `irq_done` retires the most urgent level in service.
- R11: With control bit 4 (nesting) clear, `irq_valid` stays low while any level is in service.
- R12: With nesting set, a request is offered during service only if its index is strictly below every index in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| per_req | input | 15 | Peripheral requests, one per ID |
| emu_req | input | 1 | Emulation request (position 0) |
| rst_req | input | 1 | Reset request (position 1) |
| pdn_req | input | 1 | Power-down request (position 2) |
| pc_ovf | input | 1 | PC stack overflow |
| loop_ovf | input | 1 | Loop stack overflow |
| noboot | input | 1 | Adds the high vector offset |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_done | input | 1 | Core finished the current handler |
| irq_valid | output | 1 | A request is offered |
| irq_idx | output | 4 | Offered position |
| irq_vector | output | 17 | Offered vector address |

## Verification
The assertions take two things for granted. The core raises `irq_ack` only while `irq_valid` is high, and it never pulses `irq_done` in the same cycle as an acknowledge, so the in-service set behaves as a stack of strictly rising urgency. The stimulus keeps to this. It acknowledges only right after seeing an offer, retires levels in separate cycles, and drives every input two nanoseconds after a rising edge. Peripheral sweeps raise one request at a time, so no two sources are ever aliased by accident.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // fixed core positions, most urgent first
   localparam int unsigned POS_EMU   = 0;
   localparam int unsigned POS_RST   = 1;
   localparam int unsigned POS_PDN   = 2;
   localparam int unsigned POS_STK   = 3;
   localparam int unsigned N_CORE    = 4;
   localparam int unsigned N_NMI     = 3;
   // register addresses
   localparam int unsigned RA_CTRL   = 0;
   localparam int unsigned RA_MASK   = 1;
   localparam int unsigned RA_PSET   = 2;
   localparam int unsigned RA_PCLR   = 3;
   localparam int unsigned RA_PRIO   = 4;
   localparam int unsigned RA_PDNBLK = 8;
   // control bits
   localparam int unsigned CB_NEST   = 4;
   localparam int unsigned CB_GIE    = 5;
   localparam int unsigned CB_PCOVF  = 10;
   localparam int unsigned CB_LPOVF  = 11;
endpackage

// File: rtl/pirq_prio_map.sv
module pirq_prio_map
   import pirq_pkg::*;
#(
   parameter int unsigned N_PERIPH = 15,
   parameter int unsigned N_BITS   = 16,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [N_BITS-1:0]   wdata,
   input  logic [N_PERIPH-1:0] per_req,
   output logic [N_BITS-1:0]   req_vec,
   output logic [N_BITS-1:0]   prio_rdata
);
   localparam int unsigned MAX_PRIO = N_BITS - N_CORE - 1;
   localparam int unsigned FPR      = N_BITS / PRIO_W;
   localparam int unsigned N_REGS   = (N_PERIPH + FPR - 1) / FPR;

   if (MAX_PRIO >= (1 << PRIO_W)) begin : g_chk_w
      $error("PRIO_W too narrow for MAX_PRIO");
   end
   if (RA_PRIO + N_REGS > RA_PDNBLK) begin : g_chk_regs
      $error("priority registers overlap the next address");
   end

   logic [PRIO_W-1:0] prio_q [N_PERIPH];

   function automatic logic [ADDR_W-1:0] reg_of(input int unsigned id);
      return ADDR_W'(RA_PRIO + id / FPR);
   endfunction

   function automatic logic [PRIO_W-1:0] sat(input logic [PRIO_W-1:0] v);
      return (int'(v) > int'(MAX_PRIO)) ? PRIO_W'(MAX_PRIO) : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_PERIPH); i++)
            prio_q[i] <= (i > int'(MAX_PRIO)) ? PRIO_W'(MAX_PRIO) : PRIO_W'(i);
      end else if (wr_en) begin
         for (int i = 0; i < int'(N_PERIPH); i++)
            if (addr == reg_of(i))
               prio_q[i] <= sat(wdata[(i % FPR) * PRIO_W +: PRIO_W]);
      end
   end

   always_comb begin
      req_vec = '0;
      for (int i = 0; i < int'(N_PERIPH); i++)
         if (per_req[i]) req_vec[N_CORE + int'(prio_q[i])] = 1'b1;
   end

   always_comb begin
      prio_rdata = '0;
      for (int i = 0; i < int'(N_PERIPH); i++)
         if (addr == reg_of(i))
            prio_rdata[(i % FPR) * PRIO_W +: PRIO_W] = prio_q[i];
   end

   for (genvar g = 0; g < N_PERIPH; g++) begin : g_sat_chk
      AST_PRIO_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
         int'(prio_q[g]) <= int'(MAX_PRIO)); // R3
   end
endmodule

// File: rtl/pirq_pending.sv
module pirq_pending #(
   parameter int unsigned N_BITS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] hw_set,
   input  logic [N_BITS-1:0] sw_set,
   input  logic [N_BITS-1:0] sw_clr,
   input  logic [N_BITS-1:0] ack_clr,
   output logic [N_BITS-1:0] pend_q
);
   logic [N_BITS-1:0] any_set;
   assign any_set = hw_set | sw_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~sw_clr & ~ack_clr) | any_set;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_set != '0) |=> ((pend_q & $past(any_set)) == $past(any_set))); // R9
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_clr & ~any_set) != '0) |=> ((pend_q & $past(sw_clr & ~any_set)) == '0)); // R9
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
   parameter int unsigned N_BITS    = 16,
   parameter int unsigned VEC_W     = 17,
   parameter int unsigned STRIDE_LG = 5,
   parameter int unsigned HI_OFS    = 32'h10000,
   localparam int unsigned IDX_W    = $clog2(N_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] pend,
   input  logic [N_BITS-1:0] gate,
   input  logic              nest_en,
   input  logic              noboot,
   input  logic              ack,
   input  logic              done,
   output logic              irq_valid,
   output logic [IDX_W-1:0]  irq_idx,
   output logic [VEC_W-1:0]  irq_vector,
   output logic [N_BITS-1:0] ack_clr
);
   if ((N_BITS << STRIDE_LG) > HI_OFS) begin : g_chk_ofs
      $error("vector table overlaps the high offset");
   end
   if (HI_OFS + (N_BITS << STRIDE_LG) > (1 << VEC_W)) begin : g_chk_vw
      $error("VEC_W too narrow");
   end

   logic [N_BITS-1:0] elig, inserv_q, retire;
   logic [IDX_W-1:0]  sel_idx, is_idx;
   logic              any_elig, is_any, allow, accept;

   assign elig = pend & gate;

   always_comb begin
      sel_idx = '0;
      any_elig = 1'b0;
      for (int b = int'(N_BITS) - 1; b >= 0; b--)
         if (elig[b]) begin
            sel_idx = IDX_W'(b);
            any_elig = 1'b1;
         end
   end

   always_comb begin
      is_idx = '0;
      is_any = 1'b0;
      for (int b = int'(N_BITS) - 1; b >= 0; b--)
         if (inserv_q[b]) begin
            is_idx = IDX_W'(b);
            is_any = 1'b1;
         end
   end

   assign allow      = !is_any || (nest_en && (sel_idx < is_idx));
   assign irq_valid  = any_elig && allow;
   assign irq_idx    = sel_idx;
   assign irq_vector = (VEC_W'(sel_idx) << STRIDE_LG) + (noboot ? VEC_W'(HI_OFS) : '0);
   assign accept     = ack && irq_valid;
   assign ack_clr    = accept ? (N_BITS'(1) << sel_idx) : '0;
   assign retire     = (done && is_any) ? (N_BITS'(1) << is_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inserv_q <= '0;
      else        inserv_q <= (inserv_q & ~retire) | ack_clr;
   end

   AST_SEQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!nest_en && inserv_q != '0) |-> !irq_valid); // R11
   AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (pend[irq_idx] &&
                     ((inserv_q & ((N_BITS'(2) << irq_idx) - N_BITS'(1))) == '0))); // R12
   AST_ACK_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_valid && !done) |=> inserv_q[$past(irq_idx)]); // R10
   AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector[STRIDE_LG-1:0] == '0)); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pirq_pkg::*;
#(
   parameter int unsigned N_PERIPH  = 15,
   parameter int unsigned N_BITS    = 16,
   parameter int unsigned PRIO_W    = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned VEC_W     = 17,
   parameter int unsigned STRIDE_LG = 5,
   parameter int unsigned HI_OFS    = 32'h10000,
   localparam int unsigned IDX_W    = $clog2(N_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [N_BITS-1:0]   wdata,
   output logic [N_BITS-1:0]   rdata,
   input  logic [N_PERIPH-1:0] per_req,
   input  logic                emu_req,
   input  logic                rst_req,
   input  logic                pdn_req,
   input  logic                pc_ovf,
   input  logic                loop_ovf,
   input  logic                noboot,
   input  logic                irq_ack,
   input  logic                irq_done,
   output logic                irq_valid,
   output logic [IDX_W-1:0]    irq_idx,
   output logic [VEC_W-1:0]    irq_vector
);
   if (N_BITS < 12) begin : g_chk_bits
      $error("control register needs at least 12 bits");
   end
   if ((1 << ADDR_W) <= RA_PDNBLK) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end

   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(RA_MASK);
   localparam logic [ADDR_W-1:0] AD_PSET = ADDR_W'(RA_PSET);
   localparam logic [ADDR_W-1:0] AD_PCLR = ADDR_W'(RA_PCLR);
   localparam logic [ADDR_W-1:0] AD_PBLK = ADDR_W'(RA_PDNBLK);
   localparam logic [N_BITS-1:0] CTRL_WM = (N_BITS'(1) << CB_NEST) | (N_BITS'(1) << CB_GIE)
                                         | (N_BITS'(1) << CB_PCOVF) | (N_BITS'(1) << CB_LPOVF);

   logic [N_BITS-1:0] ctrl_q, mask_q, pend, per_vec, prio_rdata;
   logic [N_BITS-1:0] hw_set, sw_set, sw_clr, ack_clr, gate;
   logic              pdnblk_q, stk_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         mask_q   <= '0;
         pdnblk_q <= 1'b0;
      end else if (wr_en) begin
         if (addr == AD_CTRL) ctrl_q   <= wdata & CTRL_WM;
         if (addr == AD_MASK) mask_q   <= wdata;
         if (addr == AD_PBLK) pdnblk_q <= wdata[0];
      end
   end

   assign stk_req = (pc_ovf && ctrl_q[CB_PCOVF]) || (loop_ovf && ctrl_q[CB_LPOVF]);

   always_comb begin
      hw_set = per_vec;
      hw_set[POS_EMU] = emu_req;
      hw_set[POS_RST] = rst_req;
      hw_set[POS_PDN] = pdn_req;
      hw_set[POS_STK] = stk_req;
   end

   assign sw_set = (wr_en && addr == AD_PSET) ? wdata : '0;
   assign sw_clr = (wr_en && addr == AD_PCLR) ? wdata : '0;

   for (genvar b = 0; b < N_BITS; b++) begin : g_gate
      if (b == POS_PDN) begin : g_pdn
         assign gate[b] = !pdnblk_q;
      end else if (b < N_NMI) begin : g_nmi
         assign gate[b] = 1'b1;
      end else begin : g_mskd
         assign gate[b] = mask_q[b] && ctrl_q[CB_GIE];
      end
   end

   always_comb begin
      case (addr)
         AD_CTRL:          rdata = ctrl_q;
         AD_MASK:          rdata = mask_q;
         AD_PSET, AD_PCLR: rdata = pend;
         AD_PBLK:          rdata = {{(N_BITS-1){1'b0}}, pdnblk_q};
         default:          rdata = prio_rdata;
      endcase
   end

   pirq_prio_map #(.N_PERIPH(N_PERIPH), .N_BITS(N_BITS), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .per_req(per_req), .req_vec(per_vec), .prio_rdata(prio_rdata));

   pirq_pending #(.N_BITS(N_BITS)) u_pend (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
      .ack_clr(ack_clr), .pend_q(pend));

   pirq_arbiter #(.N_BITS(N_BITS), .VEC_W(VEC_W), .STRIDE_LG(STRIDE_LG), .HI_OFS(HI_OFS)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend(pend), .gate(gate), .nest_en(ctrl_q[CB_NEST]),
      .noboot(noboot), .ack(irq_ack), .done(irq_done), .irq_valid(irq_valid),
      .irq_idx(irq_idx), .irq_vector(irq_vector), .ack_clr(ack_clr));

   AST_PDN_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_idx == IDX_W'(POS_PDN)) |-> !pdnblk_q); // R6
   AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !ctrl_q[CB_GIE]) |-> (int'(irq_idx) < int'(N_NMI))); // R4
   AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ovf && !ctrl_q[CB_PCOVF] && !loop_ovf && !pend[POS_STK] && !sw_set[POS_STK])
      |=> !pend[POS_STK]); // R8
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [14:0] per_req = '0;
   logic        emu_req = 1'b0, rst_req = 1'b0, pdn_req = 1'b0;
   logic        pc_ovf = 1'b0, loop_ovf = 1'b0, noboot = 1'b0;
   logic        irq_ack = 1'b0, irq_done = 1'b0;
   logic        irq_valid;
   logic [3:0]  irq_idx;
   logic [16:0] irq_vector;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .per_req(per_req), .emu_req(emu_req), .rst_req(rst_req), .pdn_req(pdn_req),
      .pc_ovf(pc_ovf), .loop_ovf(loop_ovf), .noboot(noboot), .irq_ack(irq_ack),
      .irq_done(irq_done), .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_vector(irq_vector));

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
      addr = a;
      #1;
      check(req, 32'(rdata), 32'(exp));
   endtask

   task automatic ack_once();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic done_once();
      irq_done = 1'b1; tick(); irq_done = 1'b0;
   endtask

   task automatic offer_chk(input string req, input int idx);
      if (idx < 0) check(req, 32'(irq_valid), 32'd0);
      else begin
         check(req, 32'(irq_valid), 32'd1);
         check(req, 32'(irq_idx), 32'(idx));
      end
   endtask

   initial begin
      #(8 * 190000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset contents
      check("R1", 32'(irq_valid), 0);
      rd_chk("R1", 4'd4, 16'h3210);
      rd_chk("R1", 4'd5, 16'h7654);
      rd_chk("R1", 4'd6, 16'hBA98);
      rd_chk("R1", 4'd7, 16'h0BBB);
      rd_chk("R1", 4'd0, 16'h0000);
      rd_chk("R1", 4'd1, 16'h0000);
      rd_chk("R1", 4'd2, 16'h0000);
      rd_chk("R1", 4'd8, 16'h0000);

      // R1/R2: reset mapping of every peripheral, sequential mode
      wr(4'd0, 16'h0020);
      wr(4'd1, 16'hFFFF);
      for (int i = 0; i < 15; i++) begin
         per_req[i] = 1'b1; tick(); per_req = '0;
         offer_chk("R1", ((i > 11) ? 11 : i) + 4);
         ack_once();
         check("R10", 32'(irq_valid), 0);
         done_once();
      end

      // R2/R5: every peripheral at every level, vector with and without offset
      for (int i = 0; i < 15; i++) begin
         for (int p = 0; p < 12; p++) begin
            noboot = 1'((i + p) % 2);
            wr(4'(4 + i / 4), 16'(p << ((i % 4) * 4)));
            per_req[i] = 1'b1; tick(); per_req = '0;
            offer_chk("R2", p + 4);
            check("R5", 32'(irq_vector), 32'((p + 4) * 32 + (noboot ? 32'h10000 : 0)));
            ack_once();
            rd_chk("R10", 4'd2, 16'h0000);
            done_once();
         end
      end
      noboot = 1'b0;

      // R3: saturation of an over-range level
      for (int v = 0; v < 16; v++) begin
         wr(4'd4, 16'(v));
         rd_chk("R3", 4'd4, 16'((v > 11) ? 11 : v));
      end

      // R4/R9: mixed pending, mask and enable patterns
      for (int k = 0; k < 40; k++) begin
         logic [15:0] pv, mv;
         logic        ge;
         int          exp_i;
         pv = (16'(k) * 16'h9E37 + 16'h1234) & 16'hFFF8;
         mv = (16'(k) * 16'h3B1D) ^ 16'hA5A5;
         ge = k[0];
         exp_i = -1;
         for (int b = 15; b >= 3; b--) if (pv[b] && mv[b] && ge) exp_i = b;
         wr(4'd0, ge ? 16'h0020 : 16'h0000);
         wr(4'd1, mv);
         wr(4'd2, pv);
         rd_chk("R9", 4'd2, pv);
         offer_chk("R4", exp_i);
         wr(4'd3, 16'hFFFF);
         rd_chk("R9", 4'd3, 16'h0000);
      end

      // R6: non-maskable positions
      wr(4'd0, 16'h0000);
      wr(4'd1, 16'h0000);
      wr(4'd2, 16'h0002);
      offer_chk("R6", 1);
      wr(4'd3, 16'h0002);
      pdn_req = 1'b1; tick(); pdn_req = 1'b0;
      offer_chk("R6", 2);
      wr(4'd8, 16'h0001);
      offer_chk("R6", -1);
      rd_chk("R6", 4'd2, 16'h0004);
      wr(4'd8, 16'h0000);
      offer_chk("R6", 2);
      emu_req = 1'b1; tick(); emu_req = 1'b0;
      offer_chk("R6", 0);
      wr(4'd3, 16'hFFFF);

      // R7: reserved control bits
      wr(4'd0, 16'hFFFF);
      rd_chk("R7", 4'd0, 16'h0C30);

      // R8: stack overflow gating
      wr(4'd0, 16'h0020);
      wr(4'd1, 16'h0008);
      pc_ovf = 1'b1; tick(); pc_ovf = 1'b0;
      rd_chk("R8", 4'd2, 16'h0000);
      offer_chk("R8", -1);
      wr(4'd0, 16'h0420);
      pc_ovf = 1'b1; tick(); pc_ovf = 1'b0;
      offer_chk("R8", 3);
      wr(4'd3, 16'hFFFF);
      loop_ovf = 1'b1; tick(); loop_ovf = 1'b0;
      rd_chk("R8", 4'd2, 16'h0000);
      wr(4'd0, 16'h0820);
      loop_ovf = 1'b1; tick(); loop_ovf = 1'b0;
      offer_chk("R8", 3);
      wr(4'd3, 16'hFFFF);

      // R9: hardware set beats a same-cycle clear (ID 0 at level 0 -> bit 4)
      wr(4'd4, 16'h0000);
      per_req[0] = 1'b1;
      wr(4'd3, 16'hFFFF);
      per_req = '0;
      rd_chk("R9", 4'd2, 16'h0010);
      wr(4'd3, 16'hFFFF);

      // R10/R11: sequential mode
      wr(4'd0, 16'h0020);
      wr(4'd1, 16'hFFFF);
      wr(4'd2, 16'h0100);
      offer_chk("R10", 8);
      ack_once();
      rd_chk("R10", 4'd2, 16'h0000);
      wr(4'd2, 16'h0020);
      offer_chk("R11", -1);
      done_once();
      offer_chk("R11", 5);
      ack_once();
      done_once();

      // R12: nested mode
      wr(4'd0, 16'h0030);
      wr(4'd2, 16'h0100);
      ack_once();
      wr(4'd2, 16'h0200);
      offer_chk("R12", -1);
      wr(4'd2, 16'h0040);
      offer_chk("R12", 6);
      ack_once();
      offer_chk("R12", -1);
      done_once();
      offer_chk("R12", -1);
      done_once();
      offer_chk("R12", 9);
      ack_once();
      done_once();
      wr(4'd2, 16'h0100);
      ack_once();
      wr(4'd2, 16'h0100);
      offer_chk("R12", -1);
      done_once();
      offer_chk("R12", 8);
      ack_once();
      done_once();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule